// File: doc/BRIEF.md
# Indexed Display Configuration Register Port

This block is the host-facing control window of a display adapter. The host reaches it through three word-wide ports. A word written to the selector port (port 0) picks a register number. The data port (port 1) then reads or writes the chosen register. A diagnostic port (port 2) always returns a fixed signature. Behind the data port sit the mode registers (enable, requested width and height, colour depth), an identity word, a capability word, the location and size of the command ring, cursor registers, a sync/busy flag and a bank of scratch words.

Some registers are computed from others when read: bits per pixel, bytes per line and colour masks. Some writes have side effects: an enable write drops the current size and can cancel configuration, and a depth write that does not match cancels configuration. The rest of the device receives the enable and configured flags, the requested size, an invalidate flag and a one-cycle sync request. It reports back through `ring_done_i` when the command ring has drained, and through `resize_i` when the display has taken the requested size. Register numbers are fixed, because host software decodes them.

Top module: `ixp_regport`

## Requirements
- R1: The identity register (index 0) resets to 0x90000002. A write to it takes effect only when the value is 0x90000000, 0x90000001 or 0x90000002.
- R2: A write to enable (index 1) stores the word, and reading index 1 returns it. `enable_o` is 1 when the stored word is nonzero. A zero word clears configured. Any enable write sets the current width and height (read at indices 2 and 3) to all-ones and raises `invalid_o`.
- R3: An enable write with a nonzero word loads the framebuffer size (index 16) with ((DEPTH+7)>>3) × requested width × requested height. A zero enable write leaves the framebuffer size unchanged.
- R4: Indices 7 and 28 read (DEPTH+7) with its low 3 bits cleared. Index 12 reads ((DEPTH+7)>>3) × requested width. Indices 9, 10 and 11 read the red, green and blue masks for DEPTH: 0xff0000/0xff00/0xff for depth 24 or 32, 0x1f/0x7e0/0xf800 for 16, 0x1f/0x3e0/0x7c00 for 15. Indices 8 and 14 read zero.
- R5: A write to index 6 or index 7 with a value other than DEPTH clears configured. A write with a value equal to DEPTH leaves it unchanged.
- R6: Index 4 reads 2360, index 5 reads 1770, and index 17 reads 0x3, or 0xE3 when cursor support is enabled.
- R7: Index 13 reads the framebuffer base. Index 18 reads base + MEM_BYTES − 0x10000. Index 19 reads 0x10000. Index 15 reads MEM_BYTES − 0x10000.
- R8: Indices 1024 to 1791 read zero and ignore writes. Index 1792+k, for k below SCRATCH_N, is a scratch word that can be written and read. Index 29 reads SCRATCH_N.
- R9: A write to index 27 with value 1 shows the cursor and with value 0 hides it. Any other value leaves the visible bit unchanged. Index 27 reads the visible bit. Cursor id, x and y (indices 24 to 26) and the guest word (index 23) read back what was written.
- R10: A write to index 21 sets busy and pulses `sync_req_o` for one cycle. Indices 21 and 22 read the busy flag. `ring_done_i` clears busy.
- R11: Port 2 always reads 0x0000cafe and ignores writes. Port 0 reads back the selected index. Port 3 reads zero.
- R12: A data-port read of an index that is not implemented returns zero, and `bad_index_o` is high for exactly the following cycle.
- R13: A write to index 20 sets configured to (value ≠ 0), and index 20 reads it back. Widths and heights written to indices 2 and 3 set the requested size and raise `invalid_o`. A `resize_i` pulse copies the requested size into the current size and clears `invalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_sel | input | 2 | 0 selector, 1 data, 2 diagnostic |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (used for bad-index detection) |
| wdata | input | 32 | Write word |
| rdata | output | 32 | Read word, combinational from current state |
| bad_index_o | output | 1 | One-cycle flag after a read of an unimplemented index |
| enable_o | output | 1 | Stored enable word is nonzero |
| configured_o | output | 1 | Command ring declared configured |
| new_width_o | output | 32 | Requested width |
| new_height_o | output | 32 | Requested height |
| invalid_o | output | 1 | Display must be redrawn/resized |
| sync_req_o | output | 1 | One-cycle request to drain the ring |
| busy_o | output | 1 | Sync in progress |
| ring_done_i | input | 1 | Ring drained, clears busy |
| resize_i | input | 1 | Display adopted the requested size |

## Verification
A wrong side-effect in the write decoder shows up at the ports within one cycle. Either `configured_o` or `invalid_o` holds the wrong level after an enable or depth write, or a later read of index 2, 16 or 27 returns a stale or wrongly derived value. Decoding faults in the read path are visible as soon as the index is selected, because `rdata` is combinational. A faulty known-index test shows as a missing or spurious `bad_index_o` one cycle after the read. The sweeps over indices, cursor codes and scratch words touch every decode arm, so a single misplaced constant produces a mismatch.

// File: rtl/ixp_pkg.sv
package ixp_pkg;
  localparam int unsigned IX_ID       = 0;
  localparam int unsigned IX_EN       = 1;
  localparam int unsigned IX_W        = 2;
  localparam int unsigned IX_H        = 3;
  localparam int unsigned IX_MAXW     = 4;
  localparam int unsigned IX_MAXH     = 5;
  localparam int unsigned IX_DEPTH    = 6;
  localparam int unsigned IX_BPP      = 7;
  localparam int unsigned IX_PSEUDO   = 8;
  localparam int unsigned IX_RMASK    = 9;
  localparam int unsigned IX_GMASK    = 10;
  localparam int unsigned IX_BMASK    = 11;
  localparam int unsigned IX_PITCH    = 12;
  localparam int unsigned IX_FBBASE   = 13;
  localparam int unsigned IX_FBOFS    = 14;
  localparam int unsigned IX_MEMSZ    = 15;
  localparam int unsigned IX_FBSIZE   = 16;
  localparam int unsigned IX_CAPS     = 17;
  localparam int unsigned IX_RINGBASE = 18;
  localparam int unsigned IX_RINGSZ   = 19;
  localparam int unsigned IX_CFGDONE  = 20;
  localparam int unsigned IX_SYNC     = 21;
  localparam int unsigned IX_BUSY     = 22;
  localparam int unsigned IX_GUEST    = 23;
  localparam int unsigned IX_CURID    = 24;
  localparam int unsigned IX_CURX     = 25;
  localparam int unsigned IX_CURY     = 26;
  localparam int unsigned IX_CURON    = 27;
  localparam int unsigned IX_HOSTBPP  = 28;
  localparam int unsigned IX_SCRSZ    = 29;
  localparam int unsigned IX_RSV_LO   = 30;
  localparam int unsigned IX_RSV_HI   = 32;
  localparam int unsigned IX_PAL_LO   = 1024;
  localparam int unsigned IX_PAL_HI   = 1791;
  localparam int unsigned IX_SCR_BASE = 1792;

  localparam logic [31:0] ID_REV0    = 32'h9000_0000;
  localparam logic [31:0] ID_REV1    = 32'h9000_0001;
  localparam logic [31:0] ID_REV2    = 32'h9000_0002;
  localparam logic [31:0] DIAG_WORD  = 32'h0000_cafe;
  localparam logic [31:0] RING_BYTES = 32'h0001_0000;
  localparam logic [31:0] LIMIT_W    = 32'd2360;
  localparam logic [31:0] LIMIT_H    = 32'd1770;

  typedef struct packed {
    logic [31:0] id;
    logic [31:0] enable;
    logic [31:0] cur_w;
    logic [31:0] cur_h;
    logic [31:0] new_w;
    logic [31:0] new_h;
    logic [31:0] fb_size;
    logic [31:0] guest;
    logic [31:0] cur_id;
    logic [31:0] cur_x;
    logic [31:0] cur_y;
    logic        configured;
    logic        cursor_vis;
    logic        busy;
  } ixp_state_t;

  function automatic logic [31:0] f_bits_pp(input int unsigned depth);
    return 32'(depth + 7) & ~32'd7;
  endfunction

  function automatic logic [31:0] f_bytes_pp(input int unsigned depth);
    return 32'(depth + 7) >> 3;
  endfunction

  // ch: 0 red, 1 green, 2 blue
  function automatic logic [31:0] f_mask(input int unsigned depth, input int unsigned ch);
    logic [31:0] r, g, b;
    case (depth)
      8:       begin r = 32'h07;   g = 32'h38;   b = 32'hc0;   end
      15:      begin r = 32'h1f;   g = 32'h3e0;  b = 32'h7c00; end
      16:      begin r = 32'h1f;   g = 32'h7e0;  b = 32'hf800; end
      default: begin r = 32'hff0000; g = 32'hff00; b = 32'hff; end
    endcase
    return (ch == 0) ? r : (ch == 1) ? g : b;
  endfunction

  function automatic logic id_allowed(input logic [31:0] v);
    return (v == ID_REV0) || (v == ID_REV1) || (v == ID_REV2);
  endfunction
endpackage

// File: rtl/ixp_scratch.sv
module ixp_scratch #(
  parameter int unsigned WORDS = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0] word_q [WORDS];

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) word_q[k] <= '0;
      else if (we && (32'(addr) == k)) word_q[k] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < WORDS; k++)
      if (32'(addr) == k) rdata = word_q[k];
  end
endmodule

// File: rtl/ixp_readmux.sv
module ixp_readmux
  import ixp_pkg::*;
#(
  parameter int unsigned DEPTH     = 24,
  parameter logic [31:0] FB_BASE   = 32'hE000_0000,
  parameter logic [31:0] MEM_BYTES = 32'h0040_0000,
  parameter int unsigned SCRATCH_N = 16,
  parameter bit          CURSOR_EN = 1'b1
) (
  input  logic [31:0] idx,
  input  ixp_state_t  st,
  input  logic        scr_hit,
  input  logic [31:0] scr_rdata,
  output logic [31:0] rdata,
  output logic        known
);
  localparam logic [31:0] CAPS = 32'h3 | (CURSOR_EN ? 32'hE0 : 32'h0);

  always_comb begin
    known = 1'b1;
    rdata = '0;
    case (idx)
      IX_ID:       rdata = st.id;
      IX_EN:       rdata = st.enable;
      IX_W:        rdata = st.cur_w;
      IX_H:        rdata = st.cur_h;
      IX_MAXW:     rdata = LIMIT_W;
      IX_MAXH:     rdata = LIMIT_H;
      IX_DEPTH:    rdata = 32'(DEPTH);
      IX_BPP,
      IX_HOSTBPP:  rdata = f_bits_pp(DEPTH);
      IX_PSEUDO,
      IX_FBOFS:    rdata = '0;
      IX_RMASK:    rdata = f_mask(DEPTH, 0);
      IX_GMASK:    rdata = f_mask(DEPTH, 1);
      IX_BMASK:    rdata = f_mask(DEPTH, 2);
      IX_PITCH:    rdata = f_bytes_pp(DEPTH) * st.new_w;
      IX_FBBASE:   rdata = FB_BASE;
      IX_MEMSZ:    rdata = MEM_BYTES - RING_BYTES;
      IX_FBSIZE:   rdata = st.fb_size;
      IX_CAPS:     rdata = CAPS;
      IX_RINGBASE: rdata = FB_BASE + MEM_BYTES - RING_BYTES;
      IX_RINGSZ:   rdata = RING_BYTES;
      IX_CFGDONE:  rdata = 32'(st.configured);
      IX_SYNC,
      IX_BUSY:     rdata = 32'(st.busy);
      IX_GUEST:    rdata = st.guest;
      IX_CURID:    rdata = st.cur_id;
      IX_CURX:     rdata = st.cur_x;
      IX_CURY:     rdata = st.cur_y;
      IX_CURON:    rdata = 32'(st.cursor_vis);
      IX_SCRSZ:    rdata = 32'(SCRATCH_N);
      default: begin
        if ((idx >= IX_RSV_LO && idx <= IX_RSV_HI) ||
            (idx >= IX_PAL_LO && idx <= IX_PAL_HI)) rdata = '0;
        else if (scr_hit) rdata = scr_rdata;
        else known = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ixp_regport.sv
module ixp_regport
  import ixp_pkg::*;
#(
  parameter int unsigned DEPTH     = 24,
  parameter logic [31:0] FB_BASE   = 32'hE000_0000,
  parameter logic [31:0] MEM_BYTES = 32'h0040_0000,
  parameter int unsigned SCRATCH_N = 16,
  parameter bit          CURSOR_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  port_sel,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        bad_index_o,
  output logic        enable_o,
  output logic        configured_o,
  output logic [31:0] new_width_o,
  output logic [31:0] new_height_o,
  output logic        invalid_o,
  output logic        sync_req_o,
  output logic        busy_o,
  input  logic        ring_done_i,
  input  logic        resize_i
);
  localparam int unsigned SCR_AW  = (SCRATCH_N < 2) ? 1 : $clog2(SCRATCH_N);
  localparam int unsigned SCR_END = IX_SCR_BASE + SCRATCH_N;

  ixp_state_t  st;
  logic [31:0] idx_q;
  logic        invalid_q, sync_req_q, bad_q;

  // named internal events
  logic        sel_wr, value_wr, value_rd, scr_hit, idx_known;
  logic [SCR_AW-1:0] scr_addr;
  logic [31:0] scr_rdata, mux_rdata;

  assign sel_wr   = wr_en && (port_sel == 2'd0);
  assign value_wr = wr_en && (port_sel == 2'd1);
  assign value_rd = rd_en && (port_sel == 2'd1);
  assign scr_hit  = (idx_q >= IX_SCR_BASE) && (idx_q < SCR_END);
  assign scr_addr = SCR_AW'(idx_q - IX_SCR_BASE);

  ixp_scratch #(.WORDS(SCRATCH_N), .AW(SCR_AW)) u_scratch (
    .clk(clk), .rst_n(rst_n), .we(value_wr && scr_hit),
    .addr(scr_addr), .wdata(wdata), .rdata(scr_rdata)
  );

  ixp_readmux #(.DEPTH(DEPTH), .FB_BASE(FB_BASE), .MEM_BYTES(MEM_BYTES),
                .SCRATCH_N(SCRATCH_N), .CURSOR_EN(CURSOR_EN)) u_rmux (
    .idx(idx_q), .st(st), .scr_hit(scr_hit), .scr_rdata(scr_rdata),
    .rdata(mux_rdata), .known(idx_known)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q         <= '0;
      st.id         <= ID_REV2;
      st.enable     <= '0;
      st.cur_w      <= '1;
      st.cur_h      <= '1;
      st.new_w      <= '0;
      st.new_h      <= '0;
      st.fb_size    <= '0;
      st.guest      <= '0;
      st.cur_id     <= '0;
      st.cur_x      <= '0;
      st.cur_y      <= '0;
      st.configured <= 1'b0;
      st.cursor_vis <= 1'b0;
      st.busy       <= 1'b0;
      invalid_q     <= 1'b0;
      sync_req_q    <= 1'b0;
      bad_q         <= 1'b0;
    end else begin
      sync_req_q <= 1'b0;
      bad_q      <= value_rd && !idx_known;
      if (resize_i) begin
        st.cur_w  <= st.new_w;
        st.cur_h  <= st.new_h;
        invalid_q <= 1'b0;
      end
      if (ring_done_i) st.busy <= 1'b0;
      if (sel_wr) idx_q <= wdata;
      if (value_wr) begin
        case (idx_q)
          IX_ID: if (id_allowed(wdata)) st.id <= wdata;
          IX_EN: begin
            st.enable <= wdata;
            st.cur_w  <= '1;
            st.cur_h  <= '1;
            invalid_q <= 1'b1;
            if (wdata == '0) st.configured <= 1'b0;
            else st.fb_size <= f_bytes_pp(DEPTH) * st.new_w * st.new_h;
          end
          IX_W: begin st.new_w <= wdata; invalid_q <= 1'b1; end
          IX_H: begin st.new_h <= wdata; invalid_q <= 1'b1; end
          IX_DEPTH, IX_BPP: if (wdata != 32'(DEPTH)) st.configured <= 1'b0;
          IX_CFGDONE: st.configured <= |wdata;
          IX_SYNC: begin st.busy <= 1'b1; sync_req_q <= 1'b1; end
          IX_GUEST: st.guest  <= wdata;
          IX_CURID: st.cur_id <= wdata;
          IX_CURX:  st.cur_x  <= wdata;
          IX_CURY:  st.cur_y  <= wdata;
          IX_CURON: begin
            if (wdata == 32'd1) st.cursor_vis <= 1'b1;
            else if (wdata == 32'd0) st.cursor_vis <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (port_sel)
      2'd0:    rdata = idx_q;
      2'd1:    rdata = mux_rdata;
      2'd2:    rdata = DIAG_WORD;
      default: rdata = '0;
    endcase
  end

  assign bad_index_o  = bad_q;
  assign enable_o     = |st.enable;
  assign configured_o = st.configured;
  assign new_width_o  = st.new_w;
  assign new_height_o = st.new_h;
  assign invalid_o    = invalid_q;
  assign sync_req_o   = sync_req_q;
  assign busy_o       = st.busy;

  a_r1_id_legal: assert property (@(posedge clk) disable iff (!rst_n)
    id_allowed(st.id));
  a_r2_enable_zero: assert property (@(posedge clk) disable iff (!rst_n)
    value_wr && idx_q == IX_EN && wdata == '0 |=> !configured_o && invalid_o && st.cur_w == '1);
  a_r5_depth_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    value_wr && (idx_q == IX_DEPTH || idx_q == IX_BPP) && wdata != 32'(DEPTH) |=> !configured_o);
  a_r9_cursor_keep: assert property (@(posedge clk) disable iff (!rst_n)
    value_wr && idx_q == IX_CURON && wdata > 32'd1 |=> $stable(st.cursor_vis));
  a_r10_sync_set: assert property (@(posedge clk) disable iff (!rst_n)
    value_wr && idx_q == IX_SYNC |=> busy_o && sync_req_o);
  a_r10_sync_cause: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req_o |-> $past(value_wr && idx_q == IX_SYNC));
  a_r12_bad_flag: assert property (@(posedge clk) disable iff (!rst_n)
    value_rd && !idx_known |=> bad_index_o);
  a_r12_bad_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bad_index_o) |-> $past(value_rd));
endmodule

// File: tb/ixp_regport_test.sv
module ixp_regport_test;
  localparam int unsigned D  = 24;
  localparam logic [31:0] FB = 32'hE000_0000;
  localparam logic [31:0] MB = 32'h0040_0000;
  localparam int unsigned NS = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] port_sel = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, ring_done_i = 1'b0, resize_i = 1'b0;
  logic [31:0] wdata = '0, rdata, new_width_o, new_height_o;
  logic bad_index_o, enable_o, configured_o, invalid_o, sync_req_o, busy_o;
  int checks = 0, fails = 0;
  logic last_bad;
  logic [31:0] v;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ixp_regport #(.DEPTH(D), .FB_BASE(FB), .MEM_BYTES(MB), .SCRATCH_N(NS), .CURSOR_EN(1'b1)) uut (
    .clk, .rst_n, .port_sel, .wr_en, .rd_en, .wdata, .rdata, .bad_index_o,
    .enable_o, .configured_o, .new_width_o, .new_height_o, .invalid_o,
    .sync_req_o, .busy_o, .ring_done_i, .resize_i);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); port_sel = s; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk); port_sel = s; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; last_bad = bad_index_o;
  endtask

  task automatic wreg(input logic [31:0] i, input logic [31:0] d);
    wr(2'd0, i); wr(2'd1, d);
  endtask

  task automatic rreg(input logic [31:0] i, output logic [31:0] d);
    wr(2'd0, i); rd(2'd1, d);
  endtask

  task automatic pulse_resize();
    @(negedge clk); resize_i = 1'b1; @(negedge clk); resize_i = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); ring_done_i = 1'b1; @(negedge clk); ring_done_i = 1'b0;
  endtask

  function automatic logic [31:0] exp_bpp();
    return ((D + 7) / 8) * 8;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R2 reset enable_o", 32'(enable_o), 0);
    chk("R13 reset configured_o", 32'(configured_o), 0);
    chk("R10 reset busy_o", 32'(busy_o), 0);
    chk("R12 reset bad_index_o", 32'(bad_index_o), 0);
    chk("R13 reset invalid_o", 32'(invalid_o), 0);
    rreg(0, v); chk("R1 reset id", v, 32'h9000_0002);
    rreg(2, v); chk("R2 reset width all-ones", v, 32'hFFFF_FFFF);

    // R11 diagnostic and selector ports
    rd(2'd2, v); chk("R11 diag read", v, 32'h0000_cafe);
    wr(2'd2, 32'h1234_5678);
    rd(2'd2, v); chk("R11 diag after write", v, 32'h0000_cafe);
    wr(2'd0, 32'h0000_0abc); rd(2'd0, v); chk("R11 selector readback", v, 32'h0000_0abc);
    rd(2'd3, v); chk("R11 port3 zero", v, 0);

    // R1 identity whitelist sweep
    begin
      logic [31:0] cur;
      logic [31:0] tries [6] = '{32'h9000_0000, 32'h1234_5678, 32'h9000_0001,
                                32'h9000_0003, 32'h9000_0002, 32'h0};
      cur = 32'h9000_0002;
      foreach (tries[t]) begin
        wreg(0, tries[t]);
        if (tries[t] >= 32'h9000_0000 && tries[t] <= 32'h9000_0002) cur = tries[t];
        rreg(0, v); chk("R1 id write", v, cur);
      end
    end

    // R6 / R7 constants
    rreg(4, v);  chk("R6 max width", v, 32'd2360);
    rreg(5, v);  chk("R6 max height", v, 32'd1770);
    rreg(17, v); chk("R6 caps", v, 32'h0000_00E3);
    rreg(13, v); chk("R7 fb base", v, FB);
    rreg(15, v); chk("R7 usable mem", v, MB - 32'h10000);
    rreg(18, v); chk("R7 ring start", v, FB + MB - 32'h10000);
    rreg(19, v); chk("R7 ring size", v, 32'h10000);

    // R4 derived reads
    rreg(7, v);  chk("R4 bpp", v, exp_bpp());
    rreg(28, v); chk("R4 host bpp", v, exp_bpp());
    rreg(9, v);  chk("R4 red mask", v, 32'h00ff0000);
    rreg(10, v); chk("R4 green mask", v, 32'h0000ff00);
    rreg(11, v); chk("R4 blue mask", v, 32'h000000ff);
    rreg(8, v);  chk("R4 pseudocolour zero", v, 0);
    rreg(14, v); chk("R4 fb offset zero", v, 0);

    // R13 size, configured, resize
    wreg(2, 640); wreg(3, 480);
    chk("R13 new width out", new_width_o, 640);
    chk("R13 new height out", new_height_o, 480);
    chk("R13 invalid after size write", 32'(invalid_o), 1);
    rreg(2, v); chk("R13 current width before resize", v, 32'hFFFF_FFFF);
    rreg(12, v); chk("R4 bytes per line", v, ((D + 7) / 8) * 640);
    wreg(20, 7); chk("R13 configured set", 32'(configured_o), 1);
    rreg(20, v); chk("R13 config readback", v, 1);
    pulse_resize();
    chk("R13 invalid cleared", 32'(invalid_o), 0);
    rreg(2, v); chk("R13 width after resize", v, 640);
    rreg(3, v); chk("R13 height after resize", v, 480);

    // R2 / R3 enable
    wreg(1, 5);
    chk("R2 enable_o", 32'(enable_o), 1);
    chk("R2 configured kept on nonzero", 32'(configured_o), 1);
    chk("R2 invalid on enable", 32'(invalid_o), 1);
    rreg(1, v); chk("R2 enable readback", v, 5);
    rreg(2, v); chk("R2 width all-ones", v, 32'hFFFF_FFFF);
    rreg(3, v); chk("R2 height all-ones", v, 32'hFFFF_FFFF);
    rreg(16, v); chk("R3 fb size", v, ((D + 7) / 8) * 640 * 480);
    wreg(2, 100);
    wreg(1, 0);
    chk("R2 enable_o low", 32'(enable_o), 0);
    chk("R2 configured cleared", 32'(configured_o), 0);
    rreg(16, v); chk("R3 fb size kept on zero enable", v, ((D + 7) / 8) * 640 * 480);
    wreg(1, 1);
    rreg(16, v); chk("R3 fb size recomputed", v, ((D + 7) / 8) * 100 * 480);

    // R5 depth mismatch
    wreg(20, 1);
    wreg(6, D); chk("R5 matching depth keeps", 32'(configured_o), 1);
    wreg(7, D); chk("R5 matching bpp keeps", 32'(configured_o), 1);
    wreg(7, 16); chk("R5 bpp mismatch clears", 32'(configured_o), 0);
    wreg(20, 1);
    wreg(6, 32); chk("R5 depth mismatch clears", 32'(configured_o), 0);

    // R9 cursor visible rule sweep
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 6; c++) begin
        logic expv;
        wreg(27, 32'(s));
        wreg(27, 32'(c));
        expv = (c == 1) ? 1'b1 : (c == 0) ? 1'b0 : s[0];
        rreg(27, v); chk("R9 cursor visible", v, 32'(expv));
      end
    end
    wreg(24, 32'h11); wreg(25, 32'h222); wreg(26, 32'h333); wreg(23, 32'h5007);
    rreg(24, v); chk("R9 cursor id", v, 32'h11);
    rreg(25, v); chk("R9 cursor x", v, 32'h222);
    rreg(26, v); chk("R9 cursor y", v, 32'h333);
    rreg(23, v); chk("R9 guest", v, 32'h5007);

    // R10 sync / busy
    wr(2'd0, 21); wr(2'd1, 32'h1);
    chk("R10 sync pulse", 32'(sync_req_o), 1);
    chk("R10 busy set", 32'(busy_o), 1);
    @(negedge clk);
    chk("R10 sync pulse one cycle", 32'(sync_req_o), 0);
    rreg(21, v); chk("R10 sync reads busy", v, 1);
    rreg(22, v); chk("R10 busy reads busy", v, 1);
    pulse_done();
    chk("R10 busy cleared", 32'(busy_o), 0);
    rreg(22, v); chk("R10 busy read after done", v, 0);

    // R8 palette and scratch
    begin
      logic [31:0] pal [4] = '{32'd1024, 32'd1025, 32'd1500, 32'd1791};
      foreach (pal[p]) begin
        wreg(pal[p], 32'hDEAD_0000 + 32'(p));
        rreg(pal[p], v); chk("R8 palette reads zero", v, 0);
        chk("R8 palette known", 32'(last_bad), 0);
      end
    end
    for (int k = 0; k < NS; k++) wreg(1792 + k, 32'hA5A5_0000 ^ (32'(k) * 32'h0101_0101));
    for (int k = 0; k < NS; k++) begin
      rreg(1792 + k, v); chk("R8 scratch word", v, 32'hA5A5_0000 ^ (32'(k) * 32'h0101_0101));
    end
    rreg(29, v); chk("R8 scratch size", v, NS);

    // R12 unimplemented indices
    begin
      logic [31:0] badi [5] = '{32'd33, 32'd100, 32'd1023, 32'd1792 + NS, 32'hFFFF_FFFF};
      foreach (badi[b]) begin
        wreg(badi[b], 32'h77);
        rreg(badi[b], v); chk("R12 unknown reads zero", v, 0);
        chk("R12 bad flag", 32'(last_bad), 1);
        @(negedge clk); chk("R12 bad flag one cycle", 32'(bad_index_o), 0);
      end
    end
    rreg(30, v); chk("R12 reserved reads zero", v, 0);
    chk("R12 reserved is known", 32'(last_bad), 0);
    rreg(0, v); chk("R12 known index no flag", 32'(last_bad), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule